// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog peripheral on a small single-cycle register bus. Software selects a timeout constant and an operating mode. It arms the watchdog by writing a two-byte key to the feed register. From that point, a fixed divide-by-4 prescaler drives a 24-bit down-counter. Each valid key pair reloads the counter from the timeout constant.

If software stops feeding, the counter runs out. The block then either latches an interrupt flag and raises an interrupt request, or drives a sticky system-reset request. The choice between the two is made by a mode bit.

A feed that has started (first key byte written) must be finished by the second key byte alone. Once the watchdog is armed, any other access to one of its registers at that point is treated as a fault and triggers the same action as a timeout.

Register offsets:
- 0x0 mode
- 0x4 timeout constant
- 0x8 feed
- 0xC live counter value

Top module: `wdog_keyed`

## Requirements
- R1: After reset, mode (offset 0x0) reads 0, the timeout constant (offset 0x4) reads 0x0000_00FF, the counter value (offset 0xC) reads 0x0000_00FF, and `wd_irq` and `wd_sys_rst` are low.
- R2: A write to offset 0x4 stores bits 23:0 of the write data. If that value is below 0xFF, 0xFF is stored instead. Bits 31:24 always read back as 0.
- R3: A valid feed is a write of 0xAA to offset 0x8 (bits 7:0) followed, as the very next register access, by a write of 0x55. It loads the counter from the timeout constant whether or not the watchdog is enabled. A lone 0x55 has no effect.
- R4: Setting the enable bit (mode bit 0) without a valid feed leaves the counter still and produces neither interrupt nor reset.
- R5: A valid feed completed while enable is set arms the watchdog. The counter then decrements once every 4 clocks. With constant C, the timeout action becomes visible exactly 4*C clocks after the clock edge that accepted the 0x55 write. The counter value is never 0.
- R6: With reset-enable (mode bit 1) clear, a timeout sets the interrupt flag (mode bit 2) and raises `wd_irq`. Writing 0 to bit 2 clears the flag. Writing 1 to bit 2 leaves it unchanged.
- R7: With reset-enable set, a timeout asserts `wd_sys_rst`, which stays high until `rst_n` is asserted. While it is high, the interrupt flag and `wd_irq` are held low.
- R8: The enable and reset-enable bits can be set by software but not cleared. Only `rst_n` clears them.
- R9: While armed, after 0xAA has been written, any other register access (read or write, any offset, or a feed write of anything but 0x55) triggers the timeout action. The action is visible after the second rising clock edge, counting the edge that accepts the offending access as the first.
- R10: Before the watchdog is armed, such a broken feed sequence produces no interrupt and no reset, and a later valid feed still works.
- R11: The feed register reads as 0, and writes to the counter value register (offset 0xC) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| wd_irq | output | 1 | Interrupt request, equal to the interrupt flag |
| wd_sys_rst | output | 1 | Sticky system-reset request |

## Verification
The assertions assume each bus access lasts exactly one clock and that the bus inputs are stable around the capturing edge. They also assume that `rst_n` is only released while the bus is idle. The bench drives every access for one clock from the falling edge, returns `bus_sel` to 0 between accesses, and holds the bus idle during reset. It also never places an unintended access between the two key bytes, except in the scenarios that deliberately break the sequence.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned REG_ADDR_W = 4;

  localparam logic [REG_ADDR_W-1:0] OFS_MODE  = 4'h0;
  localparam logic [REG_ADDR_W-1:0] OFS_TMO   = 4'h4;
  localparam logic [REG_ADDR_W-1:0] OFS_FEED  = 4'h8;
  localparam logic [REG_ADDR_W-1:0] OFS_VALUE = 4'hC;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  // mode register bit positions
  localparam int unsigned MB_EN    = 0;
  localparam int unsigned MB_RSTEN = 1;
  localparam int unsigned MB_FLAG  = 2;

  typedef enum logic {
    FG_IDLE  = 1'b0,
    FG_KEYED = 1'b1
  } feed_state_e;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = run & ~restart;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      logic [PW-1:0] pre_q, pre_d;
      logic          pre_en;

      assign pre_en = restart | run;

      always_comb begin
        pre_d = pre_q;
        if (restart) begin
          pre_d = '0;
        end else if (run) begin
          pre_d = (pre_q == LAST) ? '0 : pre_q + PW'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else if (pre_en) begin
          pre_q <= pre_d;
        end
      end

      assign tick = run & ~restart & (pre_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int unsigned            CNT_W   = 24,
  parameter logic [CNT_W-1:0]       RST_VAL = 24'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_end;

  assign at_end = (cnt_q <= CNT_W'(1));
  assign expire = tick & ~load & at_end;
  assign cnt_en = load | tick;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      cnt_d = at_end ? load_val : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/wdog_feed_guard.sv
module wdog_feed_guard
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       feed_wr,
  input  logic [7:0] wbyte,
  input  logic       armed,
  output logic       feed_ok,
  output logic       fault_pend
);

  feed_state_e st_q, st_d;
  logic        fault_d, fault_q;
  logic        first_key, second_key;

  assign first_key  = acc & feed_wr & (wbyte == KEY_FIRST);
  assign second_key = acc & feed_wr & (wbyte == KEY_SECOND);

  always_comb begin
    st_d    = st_q;
    fault_d = 1'b0;
    feed_ok = 1'b0;
    unique case (st_q)
      FG_IDLE: begin
        if (first_key) st_d = FG_KEYED;
      end
      FG_KEYED: begin
        if (acc) begin
          st_d = FG_IDLE;
          if (second_key) begin
            feed_ok = 1'b1;
          end else begin
            fault_d = armed;
          end
        end
      end
      default: st_d = FG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FG_IDLE;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_q <= fault_d;
    end
  end

  assign fault_pend = fault_q;

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned PRESCALE  = 4,
  parameter int unsigned MIN_CONST = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_irq,
  output logic              wd_sys_rst
);

  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CONST);
  localparam int unsigned      PAD_W = DATA_W - CNT_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[1];

  // address decode
  logic hit_mode, hit_tmo, hit_feed, hit_val;
  logic wr_mode, wr_tmo, wr_feed, rd_acc;

  assign hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
  assign hit_tmo  = (bus_addr == ADDR_W'(OFS_TMO));
  assign hit_feed = (bus_addr == ADDR_W'(OFS_FEED));
  assign hit_val  = (bus_addr == ADDR_W'(OFS_VALUE));

  assign wr_mode = bus_sel & bus_we & hit_mode;
  assign wr_tmo  = bus_sel & bus_we & hit_tmo;
  assign wr_feed = bus_we & hit_feed;
  assign rd_acc  = bus_sel & ~bus_we;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

  function automatic logic [CNT_W-1:0] clamp_tmo(input logic [CNT_W-1:0] v);
    return (v < FLOOR) ? FLOOR : v;
  endfunction

  // state registers
  logic             en_q, en_d;
  logic             rsten_q, rsten_d;
  logic             flag_q, flag_d;
  logic             sysrst_q, sysrst_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] tmo_q, tmo_d;

  logic             feed_ok, fault_pend;
  logic             tick, expire, wd_event;
  logic [CNT_W-1:0] cnt_val;

  wdog_feed_guard u_guard (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .acc        (bus_sel),
    .feed_wr    (wr_feed),
    .wbyte      (bus_wdata[7:0]),
    .armed      (armed_q),
    .feed_ok    (feed_ok),
    .fault_pend (fault_pend)
  );

  wdog_prescaler #(
    .DIV (PRESCALE)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (armed_q),
    .restart (feed_ok),
    .tick    (tick)
  );

  wdog_down_counter #(
    .CNT_W   (CNT_W),
    .RST_VAL (FLOOR)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (feed_ok),
    .load_val (tmo_q),
    .tick     (tick),
    .cnt      (cnt_val),
    .expire   (expire)
  );

  assign wd_event = expire | fault_pend;

  always_comb begin
    en_d     = en_q    | (wr_mode & bus_wdata[MB_EN]);
    rsten_d  = rsten_q | (wr_mode & bus_wdata[MB_RSTEN]);
    armed_d  = armed_q | (feed_ok & en_q);
    sysrst_d = sysrst_q | (wd_event & rsten_q);
    tmo_d    = wr_tmo ? clamp_tmo(bus_wdata[CNT_W-1:0]) : tmo_q;

    flag_d = flag_q;
    if (wr_mode && !bus_wdata[MB_FLAG]) flag_d = 1'b0;
    if (wd_event && !rsten_q)           flag_d = 1'b1;
    if (sysrst_d)                       flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      en_q     <= 1'b0;
      rsten_q  <= 1'b0;
      flag_q   <= 1'b0;
      sysrst_q <= 1'b0;
      armed_q  <= 1'b0;
      tmo_q    <= FLOOR;
    end else begin
      en_q     <= en_d;
      rsten_q  <= rsten_d;
      flag_q   <= flag_d;
      sysrst_q <= sysrst_d;
      armed_q  <= armed_d;
      if (wr_tmo) tmo_q <= tmo_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      if (hit_mode) begin
        bus_rdata[MB_EN]    = en_q;
        bus_rdata[MB_RSTEN] = rsten_q;
        bus_rdata[MB_FLAG]  = flag_q;
      end else if (hit_tmo) begin
        bus_rdata = {{PAD_W{1'b0}}, tmo_q};
      end else if (hit_val) begin
        bus_rdata = {{PAD_W{1'b0}}, cnt_val};
      end
    end
  end

  assign wd_irq     = flag_q;
  assign wd_sys_rst = sysrst_q;

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned MIN_CONST = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             rst_en,
  input logic             armed,
  input logic             fault_pend,
  input logic [CNT_W-1:0] tmo,
  input logic [CNT_W-1:0] cnt,
  input logic             wd_irq,
  input logic             wd_sys_rst
);

  assert_const_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tmo >= CNT_W'(MIN_CONST));

  assert_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);

  assert_sysrst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_sys_rst |=> wd_sys_rst);

  assert_sysrst_masks_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_sys_rst |-> !wd_irq);

  assert_en_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  assert_rsten_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_en |=> rst_en);

  assert_fault_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pend |=> (wd_sys_rst || wd_irq));

  assert_unarmed_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !$rose(wd_sys_rst) && !$rose(wd_irq));

endmodule

bind wdog_keyed wdog_keyed_chk #(
  .CNT_W     (CNT_W),
  .MIN_CONST (MIN_CONST)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en_q),
  .rst_en     (rsten_q),
  .armed      (armed_q),
  .fault_pend (fault_pend),
  .tmo        (tmo_q),
  .cnt        (cnt_val),
  .wd_irq     (wd_irq),
  .wd_sys_rst (wd_sys_rst)
);

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wd_irq;
  logic        wd_sys_rst;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  wdog_keyed uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .wd_irq     (wd_irq),
    .wd_sys_rst (wd_sys_rst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    bus_sel   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // returns at the falling edge after the accepting rising edge
  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic feed();
    bus_wr(4'h8, 32'hAA);
    bus_wr(4'h8, 32'h55);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    check("R1", "wd_irq", {31'b0, wd_irq}, 32'h0);
    check("R1", "wd_sys_rst", {31'b0, wd_sys_rst}, 32'h0);
    bus_rd(4'h0, d); check("R1", "mode", d, 32'h0);
    bus_rd(4'h4, d); check("R1", "const", d, 32'hFF);
    bus_rd(4'hC, d); check("R1", "value", d, 32'hFF);
  endtask

  task automatic t_const_clamp();
    logic [31:0] d;
    do_reset();
    bus_wr(4'h4, 32'h10);        bus_rd(4'h4, d); check("R2", "below floor", d, 32'hFF);
    bus_wr(4'h4, 32'h1234);      bus_rd(4'h4, d); check("R2", "plain", d, 32'h1234);
    bus_wr(4'h4, 32'hFF00_0300); bus_rd(4'h4, d); check("R2", "upper dropped", d, 32'h300);
    bus_wr(4'h4, 32'hFE);        bus_rd(4'h4, d); check("R2", "0xFE", d, 32'hFF);
    bus_wr(4'h4, 32'hFF);        bus_rd(4'h4, d); check("R2", "0xFF", d, 32'hFF);
  endtask

  task automatic t_feed_reload();
    logic [31:0] d;
    do_reset();
    bus_wr(4'h4, 32'h300);
    bus_wr(4'h8, 32'h55);
    bus_rd(4'hC, d); check("R3", "lone 0x55", d, 32'hFF);
    feed();
    bus_rd(4'hC, d); check("R3", "reload disabled", d, 32'h300);
    repeat (20) @(negedge clk);
    bus_rd(4'hC, d); check("R3", "no count when disabled", d, 32'h300);
  endtask

  task automatic t_enable_alone();
    logic [31:0] d;
    do_reset();
    bus_wr(4'h0, 32'h1);
    repeat (200) @(negedge clk);
    bus_rd(4'hC, d); check("R4", "value still", d, 32'hFF);
    check("R4", "no irq", {31'b0, wd_irq}, 32'h0);
    check("R4", "no reset", {31'b0, wd_sys_rst}, 32'h0);
  endtask

  task automatic t_interval_irq();
    logic [31:0] d;
    do_reset();
    bus_wr(4'h4, 32'h100);
    bus_wr(4'h0, 32'h1);
    feed();                                           // at N0
    bus_rd(4'hC, d); check("R5", "value N1", d, 32'h100);
    bus_rd(4'hC, d); check("R5", "value N3", d, 32'h100);
    bus_rd(4'hC, d); check("R5", "value N5", d, 32'hFF);
    repeat (4 * 256 - 1 - 6) @(negedge clk);
    check("R5", "irq before 4C", {31'b0, wd_irq}, 32'h0);
    @(negedge clk);
    check("R5", "irq at 4C", {31'b0, wd_irq}, 32'h1);
    bus_rd(4'h0, d); check("R6", "mode flag", d, 32'h5);
    bus_wr(4'h0, 32'h5);
    check("R6", "write 1 keeps flag", {31'b0, wd_irq}, 32'h1);
    bus_wr(4'h0, 32'h0);
    check("R6", "write 0 clears", {31'b0, wd_irq}, 32'h0);
    bus_rd(4'h0, d); check("R8", "en sticky", d, 32'h1);
    check("R6", "no reset in irq mode", {31'b0, wd_sys_rst}, 32'h0);
  endtask

  task automatic t_reset_mode();
    logic [31:0] d;
    do_reset();
    bus_wr(4'h4, 32'h100);
    bus_wr(4'h0, 32'h3);
    feed();
    repeat (4 * 256 - 1) @(negedge clk);
    check("R7", "rst before 4C", {31'b0, wd_sys_rst}, 32'h0);
    @(negedge clk);
    check("R7", "rst at 4C", {31'b0, wd_sys_rst}, 32'h1);
    check("R7", "irq low", {31'b0, wd_irq}, 32'h0);
    bus_wr(4'h0, 32'h0);
    bus_rd(4'h0, d); check("R8", "bits sticky", d, 32'h3);
    repeat (50) @(negedge clk);
    check("R7", "rst held", {31'b0, wd_sys_rst}, 32'h1);
  endtask

  task automatic t_fault_irq();
    logic [31:0] d;
    do_reset();
    bus_wr(4'h0, 32'h1);
    feed();
    bus_wr(4'h8, 32'hAA);
    bus_rd(4'h4, d);
    check("R9", "irq after 1st edge", {31'b0, wd_irq}, 32'h0);
    @(negedge clk);
    check("R9", "irq after 2nd edge", {31'b0, wd_irq}, 32'h1);
  endtask

  task automatic t_fault_reset();
    do_reset();
    bus_wr(4'h0, 32'h3);
    feed();
    bus_wr(4'h8, 32'hAA);
    bus_wr(4'h8, 32'h12);
    check("R9", "rst after 1st edge", {31'b0, wd_sys_rst}, 32'h0);
    @(negedge clk);
    check("R9", "rst after 2nd edge", {31'b0, wd_sys_rst}, 32'h1);
  endtask

  task automatic t_fault_ignored();
    logic [31:0] d;
    do_reset();
    bus_wr(4'h0, 32'h1);
    bus_wr(4'h8, 32'hAA);
    bus_rd(4'h4, d);
    repeat (10) @(negedge clk);
    check("R10", "no irq", {31'b0, wd_irq}, 32'h0);
    check("R10", "no reset", {31'b0, wd_sys_rst}, 32'h0);
    bus_wr(4'h4, 32'h500);
    feed();
    bus_rd(4'hC, d); check("R10", "later feed works", d, 32'h500);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    do_reset();
    bus_wr(4'hC, 32'h1234);
    bus_rd(4'hC, d); check("R11", "value ignores write", d, 32'hFF);
    bus_rd(4'h8, d); check("R11", "feed reads 0", d, 32'h0);
  endtask

  initial begin
    t_reset_state();
    t_const_clamp();
    t_feed_reload();
    t_enable_alone();
    t_interval_irq();
    t_reset_mode();
    t_fault_irq();
    t_fault_reset();
    t_fault_ignored();
    t_readonly();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule